// File: doc/BRIEF.md
# Boundary-Scan Instruction Register with Decode and Bypass

This block holds the instruction register of a small boundary-scan test port. A TAP state machine outside the block reports its state as one-hot strobes (test-logic-reset, capture-IR, shift-IR, update-IR, capture-DR, shift-DR). The block uses them together with the test clock and serial input. A two-bit shift stage captures a fixed pattern and then takes a new instruction from the serial input, least significant bit first. On update the shift stage is copied into a held instruction. The held instruction is decoded into three outputs: boundary path selected, bypass path selected, and external-test mode.

The block also holds the one-bit bypass register. It drives the serial output through a registered multiplexer that changes on the falling test-clock edge. The output enable is low whenever the controller is not in a shift state. The serial input is sampled on the rising edge and the serial output changes on the falling edge, which supports a test clock up to 50 MHz. The boundary cells are outside the block, and their serial output arrives as an input.

Top module: `jtag_ir_ctrl`

## Requirements
- R1: On a rising edge in capture-IR the shift stage loads binary 01, so the first two bits presented on `tdo` in the following shift-IR are 1 and then 0.
- R2: In shift-IR each rising edge moves the shift stage one place toward bit 0 and puts `tdi` into bit 1. Bit 0 leaves first on `tdo`, so a bit shifted in reaches `tdo` two shifts later, and an instruction is sent least significant bit first.
- R3: `ir_q` (bit 1 is the MSB of the opcode) changes only on a falling edge in update-IR or on test-logic-reset. Capture and shift of a new instruction leave it unchanged.
- R4: Opcode 00 (external test) asserts `sel_bsr` and `extest_en` and deasserts `sel_byp`.
- R5: Opcode 10 (sample) asserts `sel_bsr` and deasserts `sel_byp` and `extest_en`.
- R6: Opcodes 11 and 01 both select bypass: `sel_byp` is 1 and `sel_bsr` and `extest_en` are 0. Exactly one of `sel_bsr` and `sel_byp` is high at all times.
- R7: `st_tlr` asynchronously forces `ir_q` to 11 and `tdo_oe` to 0. When it coincides with update-IR, the reset wins.
- R8: The bypass register loads 0 on a rising edge in capture-DR and takes `tdi` on a rising edge in shift-DR, so in bypass `tdo` repeats `tdi` one clock later.
- R9: `tdo` is registered on the falling edge. In shift-IR it carries shift-stage bit 0. In shift-DR it carries `bsr_tdo` when the boundary path is selected and the bypass bit otherwise.
- R10: `tdo_oe` is 1 after a falling edge in shift-IR or shift-DR and 0 after a falling edge in any other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| tdi | input | 1 | Serial test data in |
| bsr_tdo | input | 1 | Serial output of the external boundary register |
| st_tlr | input | 1 | Controller in test-logic-reset (asynchronous reset) |
| st_cap_ir | input | 1 | Controller in capture-IR |
| st_shift_ir | input | 1 | Controller in shift-IR |
| st_upd_ir | input | 1 | Controller in update-IR |
| st_cap_dr | input | 1 | Controller in capture-DR |
| st_shift_dr | input | 1 | Controller in shift-DR |
| tdo | output | 1 | Serial test data out |
| tdo_oe | output | 1 | Output enable for the tdo driver |
| ir_q | output | 2 | Held instruction |
| sel_bsr | output | 1 | Boundary register is the selected data path |
| sel_byp | output | 1 | Bypass register is the selected data path |
| extest_en | output | 1 | External-test mode active |

## Verification
Test-logic-reset and update-IR can act on the same falling edge. The bench first loads external test and shifts sample into the shift stage. It then raises the reset strobe together with the update strobe across that edge and expects the held instruction to read bypass afterwards, not sample. A second overlap is the falling edge that registers `tdo` while the rising-edge bypass stage is about to change. The bench samples `tdo` just before and just after the falling edge, and expects the old value before and the new path bit after.

// File: rtl/jtag_ir_pkg.sv
package jtag_ir_pkg;

    localparam int IR_W = 2;

    typedef enum logic [IR_W-1:0] {
        OP_EXTEST = 2'b00,
        OP_SPARE  = 2'b01,
        OP_SAMPLE = 2'b10,
        OP_BYPASS = 2'b11
    } ir_op_e;

    localparam logic [IR_W-1:0] IR_CAPTURE = 2'b01;

    typedef struct packed {
        logic [IR_W-1:0] sh;
        logic            byp;
    } rise_st_t;

    typedef struct packed {
        logic [IR_W-1:0] ir;
        logic            tdo;
        logic            oe;
    } fall_st_t;

    typedef struct packed {
        logic sel_bsr;
        logic sel_byp;
        logic extest;
    } dec_t;

endpackage

// File: rtl/jtag_ir_shift.sv
module jtag_ir_shift
    import jtag_ir_pkg::*;
(
    input  logic            tck,
    input  logic            tlr,
    input  logic            tdi,
    input  logic            cap_ir,
    input  logic            shift_ir,
    input  logic            cap_dr,
    input  logic            shift_dr,
    output logic [IR_W-1:0] sh_q,
    output logic            byp_q
);

    rise_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cap_ir) begin
            st_d.sh = IR_CAPTURE;
        end else if (shift_ir) begin
            st_d.sh = {tdi, st_q.sh[IR_W-1:1]};
        end
        if (cap_dr) begin
            st_d.byp = 1'b0;
        end else if (shift_dr) begin
            st_d.byp = tdi;
        end
    end

    always_ff @(posedge tck or posedge tlr) begin
        if (tlr) begin
            st_q <= '{sh: IR_CAPTURE, byp: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sh_q  = st_q.sh;
    assign byp_q = st_q.byp;

    // R1
    capture_pattern_chk: assert property (@(posedge tck) disable iff (tlr)
        $past(cap_ir) |-> (st_q.sh == IR_CAPTURE));

    // R2
    shift_entry_chk: assert property (@(posedge tck) disable iff (tlr)
        ($past(shift_ir) && !$past(cap_ir)) |-> (st_q.sh[IR_W-1] == $past(tdi)));

    // R8
    bypass_capture_chk: assert property (@(posedge tck) disable iff (tlr)
        $past(cap_dr) |-> (st_q.byp == 1'b0));

    // R8
    bypass_shift_chk: assert property (@(posedge tck) disable iff (tlr)
        ($past(shift_dr) && !$past(cap_dr)) |-> (st_q.byp == $past(tdi)));

endmodule

// File: rtl/jtag_ir_decode.sv
module jtag_ir_decode
    import jtag_ir_pkg::*;
(
    input  logic [IR_W-1:0] ir,
    output dec_t            dec
);

    always_comb begin
        dec = '{sel_bsr: 1'b0, sel_byp: 1'b1, extest: 1'b0};
        unique case (ir_op_e'(ir))
            OP_EXTEST: dec = '{sel_bsr: 1'b1, sel_byp: 1'b0, extest: 1'b1};
            OP_SAMPLE: dec = '{sel_bsr: 1'b1, sel_byp: 1'b0, extest: 1'b0};
            OP_BYPASS,
            OP_SPARE:  dec = '{sel_bsr: 1'b0, sel_byp: 1'b1, extest: 1'b0};
            default:   dec = '{sel_bsr: 1'b0, sel_byp: 1'b1, extest: 1'b0};
        endcase
    end

endmodule

// File: rtl/jtag_ir_fall.sv
module jtag_ir_fall
    import jtag_ir_pkg::*;
(
    input  logic            tck,
    input  logic            tlr,
    input  logic            upd_ir,
    input  logic            shift_ir,
    input  logic            shift_dr,
    input  logic [IR_W-1:0] sh,
    input  logic            byp,
    input  logic            bsr_tdo,
    input  dec_t            dec,
    output logic [IR_W-1:0] ir_q,
    output logic            tdo_q,
    output logic            oe_q
);

    fall_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.oe = shift_ir | shift_dr;
        if (upd_ir) begin
            st_d.ir = sh;
        end
        if (shift_ir) begin
            st_d.tdo = sh[0];
        end else if (shift_dr) begin
            st_d.tdo = dec.sel_bsr ? bsr_tdo : byp;
        end
    end

    always_ff @(negedge tck or posedge tlr) begin
        if (tlr) begin
            st_q <= '{ir: OP_BYPASS, tdo: 1'b0, oe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ir_q  = st_q.ir;
    assign tdo_q = st_q.tdo;
    assign oe_q  = st_q.oe;

    // R3
    ir_hold_chk: assert property (@(negedge tck) disable iff (tlr)
        !$past(upd_ir) |-> $stable(st_q.ir));

    // R6
    one_path_chk: assert property (@(negedge tck) disable iff (tlr)
        $countones({dec.sel_bsr, dec.sel_byp}) == 1);

    // R4
    extest_path_chk: assert property (@(negedge tck) disable iff (tlr)
        dec.extest |-> dec.sel_bsr);

    // R10
    oe_idle_chk: assert property (@(posedge tck) disable iff (tlr)
        (!shift_ir && !shift_dr) |-> !st_q.oe);

endmodule

// File: rtl/jtag_ir_ctrl.sv
module jtag_ir_ctrl
    import jtag_ir_pkg::*;
(
    input  logic            tck,
    input  logic            tdi,
    input  logic            bsr_tdo,
    input  logic            st_tlr,
    input  logic            st_cap_ir,
    input  logic            st_shift_ir,
    input  logic            st_upd_ir,
    input  logic            st_cap_dr,
    input  logic            st_shift_dr,
    output logic            tdo,
    output logic            tdo_oe,
    output logic [IR_W-1:0] ir_q,
    output logic            sel_bsr,
    output logic            sel_byp,
    output logic            extest_en
);

    logic [IR_W-1:0] sh_w;
    logic            byp_w;
    logic [IR_W-1:0] ir_w;
    dec_t            dec_w;

    jtag_ir_shift u_shift (
        .tck      (tck),
        .tlr      (st_tlr),
        .tdi      (tdi),
        .cap_ir   (st_cap_ir),
        .shift_ir (st_shift_ir),
        .cap_dr   (st_cap_dr),
        .shift_dr (st_shift_dr),
        .sh_q     (sh_w),
        .byp_q    (byp_w)
    );

    jtag_ir_decode u_dec (
        .ir  (ir_w),
        .dec (dec_w)
    );

    jtag_ir_fall u_fall (
        .tck      (tck),
        .tlr      (st_tlr),
        .upd_ir   (st_upd_ir),
        .shift_ir (st_shift_ir),
        .shift_dr (st_shift_dr),
        .sh       (sh_w),
        .byp      (byp_w),
        .bsr_tdo  (bsr_tdo),
        .dec      (dec_w),
        .ir_q     (ir_w),
        .tdo_q    (tdo),
        .oe_q     (tdo_oe)
    );

    assign ir_q      = ir_w;
    assign sel_bsr   = dec_w.sel_bsr;
    assign sel_byp   = dec_w.sel_byp;
    assign extest_en = dec_w.extest;

endmodule

// File: tb/jtag_ir_ctrl_tb.sv
module jtag_ir_ctrl_tb_top;

    localparam int TCK_PERIOD = 20;
    localparam int QTR        = TCK_PERIOD / 4;
    localparam int NVEC       = 4;
    // each entry: {opcode[1:0], sel_bsr, sel_byp, extest_en}
    localparam logic [4:0] VEC [NVEC] = '{5'b00_101, 5'b10_100, 5'b11_010, 5'b01_010};

    logic       tck = 1'b0;
    logic       tdi = 1'b0, bsr_tdo = 1'b0;
    logic       st_tlr = 1'b1, st_cap_ir = 1'b0, st_shift_ir = 1'b0, st_upd_ir = 1'b0;
    logic       st_cap_dr = 1'b0, st_shift_dr = 1'b0;
    logic       tdo, tdo_oe, sel_bsr, sel_byp, extest_en;
    logic [1:0] ir_q;
    int         checks = 0;
    int         failures = 0;

    jtag_ir_ctrl dut_i (
        .tck(tck), .tdi(tdi), .bsr_tdo(bsr_tdo), .st_tlr(st_tlr),
        .st_cap_ir(st_cap_ir), .st_shift_ir(st_shift_ir), .st_upd_ir(st_upd_ir),
        .st_cap_dr(st_cap_dr), .st_shift_dr(st_shift_dr),
        .tdo(tdo), .tdo_oe(tdo_oe), .ir_q(ir_q),
        .sel_bsr(sel_bsr), .sel_byp(sel_byp), .extest_en(extest_en)
    );

    always #(TCK_PERIOD/2) tck = ~tck;

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic idle();
        st_cap_ir = 0; st_shift_ir = 0; st_upd_ir = 0; st_cap_dr = 0; st_shift_dr = 0;
    endtask

    // one full TCK period: falling edge then rising edge, then settle
    task automatic cyc();
        @(negedge tck);
        @(posedge tck);
        #QTR;
    endtask

    task automatic load_ir(input logic [1:0] op, input bit upd);
        idle(); st_cap_ir = 1; cyc();
        idle(); st_shift_ir = 1; tdi = op[0]; cyc();
        chk("R1 first captured bit", {3'b0, tdo}, 4'h1);
        chk("R10 oe in shift-IR", {3'b0, tdo_oe}, 4'h1);
        tdi = op[1]; cyc();
        chk("R1 second captured bit", {3'b0, tdo}, 4'h0);
        idle();
        if (upd) begin
            st_upd_ir = 1; cyc(); idle();
            chk("R10 oe after shift", {3'b0, tdo_oe}, 4'h0);
        end
    endtask

    initial begin
        #(TCK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog act=running exp=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge tck);
        #QTR;
        // reset state (R7)
        chk("R7 reset ir", {2'b0, ir_q}, 4'h3);
        chk("R7 reset oe", {3'b0, tdo_oe}, 4'h0);
        chk("R6 reset decode", {1'b0, sel_bsr, sel_byp, extest_en}, 4'b0010);
        st_tlr = 0; cyc();

        // table walk: R4 R5 R6 and R2 (opcode arrives LSB first)
        for (int i = 0; i < NVEC; i++) begin
            load_ir(VEC[i][4:3], 1'b1);
            chk("R2 loaded opcode", {2'b0, ir_q}, {2'b0, VEC[i][4:3]});
            chk("R4 R5 R6 decode", {1'b0, sel_bsr, sel_byp, extest_en}, {1'b0, VEC[i][2:0]});
        end

        // R3: shift a new opcode without update; held value unchanged
        load_ir(2'b00, 1'b1);
        load_ir(2'b11, 1'b0);
        cyc();
        chk("R3 hold without update", {2'b0, ir_q}, 4'h0);
        chk("R3 extest still active", {3'b0, extest_en}, 4'h1);

        // R2: bit shifted in appears on tdo two shifts later
        idle(); st_cap_ir = 1; cyc();
        idle(); st_shift_ir = 1;
        tdi = 1; cyc(); tdi = 1; cyc(); tdi = 0; cyc();
        chk("R2 shift-through delay", {3'b0, tdo}, 4'h1);
        idle(); cyc();

        // R8: bypass capture 0 and one-bit delay
        load_ir(2'b11, 1'b1);
        st_cap_dr = 1; cyc(); idle();
        st_shift_dr = 1; tdi = 1; cyc();
        chk("R8 bypass captured zero", {3'b0, tdo}, 4'h0);
        tdi = 0; cyc();
        chk("R8 bypass delayed one", {3'b0, tdo}, 4'h1);
        tdi = 1; cyc();
        chk("R8 bypass delayed zero", {3'b0, tdo}, 4'h0);
        chk("R10 oe in shift-DR", {3'b0, tdo_oe}, 4'h1);
        idle(); cyc();
        chk("R10 oe after shift-DR", {3'b0, tdo_oe}, 4'h0);

        // R9: boundary path, tdo changes on falling edge only
        load_ir(2'b10, 1'b1);
        st_shift_dr = 1; bsr_tdo = 0; cyc();
        chk("R9 boundary path zero", {3'b0, tdo}, 4'h0);
        bsr_tdo = 1; #1;
        chk("R9 no change before falling edge", {3'b0, tdo}, 4'h0);
        @(negedge tck); #QTR;
        chk("R9 change after falling edge", {3'b0, tdo}, 4'h1);
        @(posedge tck); #QTR;
        idle(); cyc();

        // R7: reset coinciding with update-IR wins
        load_ir(2'b00, 1'b1);
        load_ir(2'b10, 1'b0);
        st_upd_ir = 1; st_tlr = 1; cyc();
        idle(); st_tlr = 0; cyc();
        chk("R7 reset beats update", {2'b0, ir_q}, 4'h3);
        chk("R7 bypass after reset", {3'b0, sel_byp}, 4'h1);

        // R7: asynchronous reset mid-cycle
        load_ir(2'b00, 1'b1);
        st_tlr = 1; #1;
        chk("R7 async reset", {2'b0, ir_q}, 4'h3);
        cyc(); st_tlr = 0; cyc();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule